// File: doc/BRIEF.md
# CORDIC Quadrature Tone Synthesizer

This block turns a 32-bit tuning word into a matched pair of sampled sinusoids, one sine and one cosine, at a programmable frequency. A 32-bit accumulator adds the tuning word on every clock and wraps modulo 2^32, so the tone frequency is `fcw * f_clk / 2^32`. With a 100 MHz clock, 0x40000000 gives 25 MHz, 0x80000000 gives 50 MHz and 0x028F5C28 gives about 1 MHz.

The accumulator's top sixteen bits form the phase, and that phase is truncated to twelve bits. Truncating to sixteen bits and then to twelve is the same as keeping the accumulator's top twelve bits. The two most significant of those twelve bits give the quadrant. The remaining ten bits are a first-quadrant angle, and a fully unrolled CORDIC rotator turns that angle into a vector. The rotator has one register per micro-rotation, and its shift distances and arctangent constants are fixed by wiring. A final register swaps and negates the rotated vector according to the quadrant, which travels alongside the data.

The pipeline delivers one new sine/cosine pair on every clock. A valid flag marks the samples that have passed through every stage. Changing the tuning word changes the step size from the next accumulation onward. The phase is never reset when this happens.

Top module: `cordic_dds`

## Requirements
- R1: While `rst_n` is low, `valid_o` is 0 and `sin_o` and `cos_o` are 0. The accumulator restarts from phase 0.
- R2: The accumulator adds `fcw` on every clock and wraps modulo 2^32. For example, `fcw` = 0x40000000 gives a sequence with a period of four samples: (sin, cos) ≈ (0,+A), (+A,0), (0,-A), (-A,0).
- R3: The phase index used for a sample is accumulator bits [31:20], an unsigned 12-bit value, truncated and not rounded. A full turn is 4096 steps.
- R4: The output after clock edge m (counting edges since reset release, starting at 1) belongs to the accumulator value after edge m-14, so `valid_o` first rises after edge 14. That first sample has phase 0 and gives cos ≈ +A and sin ≈ 0.
- R5: For phase index p, `sin_o` is within 4 LSB of A·sin(2πp/4096) and `cos_o` is within 4 LSB of A·cos(2πp/4096). Here A = 2^(DW-1) - 2^(DW-7), which is 2016 for DW = 12.
- R6: Phase bits [11:10] select the quadrant 0..3. At the quadrant boundaries p = 0, 1024, 2048 and 3072, the outputs are (sin, cos) ≈ (0,A), (A,0), (0,-A) and (-A,0).
- R7: Once `valid_o` is 1, it stays 1 on every clock until the next reset, and every one of those clocks delivers a new sample.
- R8: With `fcw` = 0, the phase holds and the outputs stay exactly constant.
- R9: A new `fcw` takes effect on the next accumulation and continues from the current phase, with no jump and no restart.
- R10: For every valid sample, sin² + cos² lies between (A-4)² and (A+4)², and neither output exceeds A+4 in magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcw | input | 32 | Frequency tuning word, added to the phase every clock |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |
| valid_o | output | 1 | High when `sin_o`/`cos_o` hold a sample that has passed through every stage |

## Verification
A fault in the accumulator appears at the ports exactly fourteen clocks later. It shows as a sample whose phase differs from the running sum of tuning words, and after that every sample is offset. A stage with the wrong shift distance or the wrong constant bends every sample of the sweep. The error is largest where that stage's rotation decides the result, and the full 4096-phase sweep shows it within one pass of the circle. A misdelayed quadrant tag appears as a sign or swap error, but only on samples next to a quadrant change. The boundary samples at multiples of 1024 expose it directly.

// File: rtl/cordic_dds.sv
module cordic_dds #(
  parameter int ACC_W = 32,
  parameter int ANG_W = 12,
  parameter int DW    = 12,
  parameter int ITER  = 12,
  parameter int GB    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ACC_W-1:0]     fcw,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o,
  output logic                 valid_o
);

  localparam int ZW  = 16;
  localparam int XW  = DW + GB;
  localparam int AMP = 2**(DW-1) - 2**(DW-7);
  localparam longint X0L = (longint'(AMP) * (64'sd1 <<< GB) * 64'sd607253) / 64'sd1000000;
  localparam logic signed [XW-1:0] X0 = XW'(X0L);

  function automatic logic signed [ZW-1:0] atan_k(input int i);
    case (i)
      0: return 16'sd8192;   1: return 16'sd4836;   2: return 16'sd2555;   3: return 16'sd1297;
      4: return 16'sd651;    5: return 16'sd326;    6: return 16'sd163;    7: return 16'sd81;
      8: return 16'sd41;     9: return 16'sd20;     10: return 16'sd10;    11: return 16'sd5;
      12: return 16'sd3;     13: return 16'sd1;     14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  logic [ACC_W-1:0]        acc;
  logic signed [XW-1:0]    xs [0:ITER];
  logic signed [XW-1:0]    ys [0:ITER];
  logic signed [ZW-1:0]    zs [0:ITER];
  logic [1:0]              qs [0:ITER];
  logic [ITER:0]           vs;

  wire [ANG_W-1:0] ang = acc[ACC_W-1 -: ANG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      xs[0] <= '0;
      ys[0] <= '0;
      zs[0] <= '0;
      qs[0] <= '0;
      vs[0] <= 1'b0;
    end else begin
      acc   <= acc + fcw;
      xs[0] <= X0;
      ys[0] <= '0;
      zs[0] <= {2'b00, ang[ANG_W-3:0], {(ZW-ANG_W){1'b0}}};
      qs[0] <= ang[ANG_W-1 -: 2];
      vs[0] <= 1'b1;
    end
  end

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic signed [ZW-1:0] AT = atan_k(i);
    wire neg = zs[i][ZW-1];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xs[i+1] <= '0;
        ys[i+1] <= '0;
        zs[i+1] <= '0;
        qs[i+1] <= '0;
        vs[i+1] <= 1'b0;
      end else begin
        xs[i+1] <= neg ? xs[i] + (ys[i] >>> i) : xs[i] - (ys[i] >>> i);
        ys[i+1] <= neg ? ys[i] - (xs[i] >>> i) : ys[i] + (xs[i] >>> i);
        zs[i+1] <= neg ? zs[i] + AT : zs[i] - AT;
        qs[i+1] <= qs[i];
        vs[i+1] <= vs[i];
      end
    end
  end

  wire signed [DW-1:0] cx = DW'(xs[ITER] >>> GB);
  wire signed [DW-1:0] cy = DW'(ys[ITER] >>> GB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sin_o   <= '0;
      cos_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= vs[ITER];
      case (qs[ITER])
        2'd0: begin sin_o <= cy;  cos_o <= cx;  end
        2'd1: begin sin_o <= cx;  cos_o <= -cy; end
        2'd2: begin sin_o <= -cy; cos_o <= -cx; end
        default: begin sin_o <= -cx; cos_o <= cy; end
      endcase
    end
  end

  localparam int RES_MAX = int'(atan_k(ITER-1)) + ITER;
  localparam int RLO = (AMP-4)*(AMP-4);
  localparam int RHI = (AMP+4)*(AMP+4);

  AST_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    vs[ITER] |-> (int'(zs[ITER]) <= RES_MAX && int'(zs[ITER]) >= -RES_MAX)); // R5
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o); // R7
  AST_RADIUS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(sin_o)*int'(sin_o) + int'(cos_o)*int'(cos_o) >= RLO &&
                 int'(sin_o)*int'(sin_o) + int'(cos_o)*int'(cos_o) <= RHI)); // R10
  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(sin_o) <= AMP+4 && int'(sin_o) >= -AMP-4 &&
                 int'(cos_o) <= AMP+4 && int'(cos_o) >= -AMP-4)); // R10
  AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vs[ITER] && $past(vs[ITER]) && zs[ITER] == $past(zs[ITER]) && qs[ITER] == $past(qs[ITER])
     && xs[ITER] == $past(xs[ITER]) && ys[ITER] == $past(ys[ITER])) |=> $stable(sin_o) && $stable(cos_o)); // R8

endmodule

// File: tb/cordic_dds_tb.sv
`timescale 1ns/1ps
module cordic_dds_tb;
  localparam int  DW  = 12;
  localparam int  LAT = 14;
  localparam real AMP = 2016.0;
  localparam real TOL = 4.0;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fcw = '0;
  logic signed [DW-1:0] sin_o, cos_o;
  logic valid_o;

  cordic_dds u_dut (.clk(clk), .rst_n(rst_n), .fcw(fcw), .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, m = 0, hold_from = -1;
  logic [31:0] hist [0:63];
  string tag = "R5";
  bit done = 0;
  logic signed [DW-1:0] prev_s, prev_c;

  task automatic chk(input bit ok, input string r, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0f expected %0f", r, what, act, exp);
    end
  endtask

  function automatic real absr(input real v);
    return v < 0.0 ? -v : v;
  endfunction

  initial hist[0] = '0;

  always @(posedge clk) if (rst_n) begin
    hist[(m+1)%64] <= hist[m%64] + fcw;
    m <= m + 1;
  end

  always @(negedge clk) if (rst_n && !done) begin
    if (m < LAT) begin
      chk(valid_o == 1'b0, "R4", "valid before latency", real'(valid_o), 0.0);
    end else begin
      int p;
      real es, ec, rad;
      p  = int'(hist[(m-LAT)%64][31:20]);
      es = AMP * $sin(2.0*PI*real'(p)/4096.0);
      ec = AMP * $cos(2.0*PI*real'(p)/4096.0);
      chk(valid_o == 1'b1, "R7", "valid continuous", real'(valid_o), 1.0);
      chk(absr(real'(sin_o) - es) <= TOL, tag, "sin", real'(sin_o), es);
      chk(absr(real'(cos_o) - ec) <= TOL, tag, "cos", real'(cos_o), ec);
      rad = $sqrt(real'(sin_o)*real'(sin_o) + real'(cos_o)*real'(cos_o));
      chk(absr(rad - AMP) <= TOL, "R10", "radius", rad, AMP);
      if (p % 1024 == 0) begin
        chk(absr(real'(sin_o) - es) <= TOL && absr(real'(cos_o) - ec) <= TOL,
            "R6", "quadrant boundary sin", real'(sin_o), es);
      end
      if (m == LAT) chk(absr(real'(cos_o) - AMP) <= TOL, "R4", "first cos", real'(cos_o), AMP);
      if (hold_from >= 0 && m > hold_from) begin
        chk(sin_o == prev_s, "R8", "sin hold", real'(sin_o), real'(prev_s));
        chk(cos_o == prev_c, "R8", "cos hold", real'(cos_o), real'(prev_c));
      end
      prev_s = sin_o;
      prev_c = cos_o;
    end
  end

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R1", "valid in reset", real'(valid_o), 0.0);
      chk(sin_o == 0 && cos_o == 0, "R1", "sin in reset", real'(sin_o), 0.0);
    end
    fcw = 32'h0010_0000;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4096 + 30) @(negedge clk);
    tag = "R2";
    fcw = 32'h4000_0000;
    repeat (60) @(negedge clk);
    tag = "R3";
    fcw = 32'h000F_FFFF;
    repeat (300) @(negedge clk);
    tag = "R8";
    fcw = 32'h0;
    hold_from = m + LAT;
    repeat (60) @(negedge clk);
    hold_from = -1;
    tag = "R9";
    fcw = 32'h028F_5C28;
    repeat (200) @(negedge clk);
    fcw = 32'h8000_0000;
    repeat (40) @(negedge clk);
    fcw = 32'h0733_1234;
    repeat (100) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule